// File: doc/BRIEF.md
# Enable/Data-Available to Zero-Latency Stream Bridge

This block joins an older-style data source, which raises a "data available" flag and answers an enable request with data one cycle later, to a frame-oriented streaming core that takes per-beat valid/ready handshakes with zero ready latency. The bridge drives the source's enable request. It registers the request to form a valid at ready latency 1, in the cycle when the data actually arrives. A two-entry skid buffer then turns that latency-1 stream into a zero-latency valid/data pair for the core. A beat counter marks the first and last beat of each frame, using a configurable frame length.

After the last real frame, a flush input makes the bridge keep the core-side valid high. It presents zero-valued padding beats so that the burst-mode core can push its final frame out. On the output side, the core's ready is taken straight from the downstream sink's room flag. Each accepted output beat is presented to the sink one cycle later as a write strobe with its data. This matches the sink's fixed one-cycle reaction.

Top module: `lsb_top`

## Requirements
- R1: While `rst` is high, `srcEna` is low whatever `srcDav` is, and once reset has been applied for at least one clock `coreValid` and `sinkWrEna` are low. Right after reset is released, with `flushIn` low, `coreValid` stays low.
- R2: Only a cycle in which both `srcEna` and `srcDav` were high produces a beat, and the data of that beat is captured from `srcData` in the following cycle. Changes on `srcData` at any other time produce no beat.
- R3: Every requested beat reaches the core exactly once and in request order, under any pattern of `srcDav` gaps and `coreReady` backpressure. The buffer never holds more than two beats.
- R4: A core-side beat is transferred only in a cycle with `coreValid` and `coreReady` both high. While `coreReady` is low and no flush padding is shown, `coreValid` and `coreData` hold in the next cycle.
- R5: With `srcDav` and `coreReady` held high from an empty state, a beat is transferred every cycle from the third cycle on (18 beats in 20 cycles).
- R6: `coreSop` is high on accepted beat k when k mod FRAME_LEN is 0, and `coreEop` is high when k mod FRAME_LEN is FRAME_LEN-1, where k counts accepted beats from 0 after reset. The count wraps after the last beat of a frame.
- R7: With `flushIn` high and the buffer empty, `coreValid` is high and `coreData` is zero. These padding beats advance the frame count like real beats.
- R8: `coreOutReady` equals `sinkRoom` in the same cycle. A core output beat accepted (`coreOutValid` and `coreOutReady` high) in cycle c appears as `sinkWrEna` high with that data in cycle c+1, and `sinkWrEna` is low otherwise.
- R9: With `coreReady` held low and `srcDav` high from an empty state, exactly two enable requests are issued, after which `srcEna` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcDav | input | 1 | Legacy source has data to offer |
| srcData | input | DATA_W | Legacy source data, valid one cycle after a granted request |
| srcEna | output | 1 | Enable request to the legacy source |
| coreValid | output | 1 | Zero-latency valid to the core |
| coreReady | input | 1 | Core ready, zero latency |
| coreData | output | DATA_W | Beat data to the core |
| coreSop | output | 1 | First beat of a frame |
| coreEop | output | 1 | Last beat of a frame |
| flushIn | input | 1 | Emit padding beats while the buffer is empty |
| coreOutValid | input | 1 | Core output beat valid |
| coreOutData | input | DATA_W | Core output beat data |
| coreOutReady | output | 1 | Ready returned to the core output |
| sinkRoom | input | 1 | Legacy sink can take data |
| sinkWrEna | output | 1 | Write strobe to the legacy sink |
| sinkData | output | DATA_W | Data to the legacy sink |

## Verification
The assertions assume that the legacy source honours its one-cycle response and that `flushIn` is raised only after the source has gone quiet, so padding never comes between real beats. They also assume that the sink tolerates the single beat already in flight when its room flag drops. The stimulus never raises flush while `srcDav` is active or the buffer holds data. Source data is driven only in the cycle after a granted request; at all other times it is random, so stray values are visible if the bridge picks them up. Backpressure and data-available gaps come from fixed rotating masks, so every stall length the masks contain is repeatable.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int BUF_DEPTH = 2;

  typedef struct packed {
    logic push;
    logic pop;
    logic wrSel;
    logic rdSel;
    logic pad;
    logic outCap;
  } bufStrobe_t;
endpackage

// File: rtl/lsb_ctrl.sv
module lsb_ctrl
  import lsb_pkg::*;
#(
  parameter int FRAME_LEN = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       srcDav,
  output logic       srcEna,
  input  logic       coreReady,
  output logic       coreValid,
  output logic       coreSop,
  output logic       coreEop,
  input  logic       flushIn,
  input  logic       coreOutValid,
  input  logic       sinkRoom,
  output logic       coreOutReady,
  output bufStrobe_t strb
);
  localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

  logic             reqD;
  logic [1:0]       occ, occNext;
  logic             wrPtr, rdPtr;
  logic [CNT_W-1:0] sampCnt;
  logic             push, pop, accept;

  // request granted last cycle => data lands now (latency-1 valid)
  always_ff @(posedge clk) begin
    if (rst) reqD <= 1'b0;
    else     reqD <= srcEna && srcDav;
  end

  assign push      = reqD;
  assign coreValid = (occ != 2'd0) || flushIn;
  assign pop       = (occ != 2'd0) && coreReady;
  assign accept    = coreValid && coreReady;

  always_comb begin
    occNext = occ;
    if (push && !pop)      occNext = occ + 2'd1;
    else if (!push && pop) occNext = occ - 2'd1;
  end

  // a request made now lands next cycle; keep one slot free for it
  assign srcEna = !rst && (occNext < 2'(BUF_DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      occ   <= 2'd0;
      wrPtr <= 1'b0;
      rdPtr <= 1'b0;
    end else begin
      occ <= occNext;
      if (push) wrPtr <= ~wrPtr;
      if (pop)  rdPtr <= ~rdPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sampCnt <= '0;
    else if (accept) sampCnt <= (sampCnt == LAST_IDX) ? '0 : sampCnt + 1'b1;
  end

  assign coreSop      = (sampCnt == '0);
  assign coreEop      = (sampCnt == LAST_IDX);
  assign coreOutReady = sinkRoom;

  always_comb begin
    strb.push   = push;
    strb.pop    = pop;
    strb.wrSel  = wrPtr;
    strb.rdSel  = rdPtr;
    strb.pad    = (occ == 2'd0);
    strb.outCap = coreOutValid && sinkRoom;
  end

  assert_ena_in_reset_R1: assert property (@(posedge clk) rst |-> !srcEna);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= 2'(BUF_DEPTH));
  assert_hold_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (coreValid && !coreReady && !flushIn) |=> coreValid);
  assert_frame_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && coreEop) |=> coreSop);
  assert_arrival_has_slot_R9: assert property (@(posedge clk) disable iff (rst)
    push |-> (occ < 2'(BUF_DEPTH)));
endmodule

// File: rtl/lsb_datapath.sv
module lsb_datapath
  import lsb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  bufStrobe_t        strb,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] coreData,
  input  logic [DATA_W-1:0] coreOutData,
  output logic              sinkWrEna,
  output logic [DATA_W-1:0] sinkData
);
  logic [DATA_W-1:0] store [BUF_DEPTH];

  for (genvar i = 0; i < BUF_DEPTH; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (strb.push && (strb.wrSel == 1'(i))) store[i] <= srcData;
    end
  end

  assign coreData = strb.pad ? '0 : store[strb.rdSel];

  always_ff @(posedge clk) begin
    if (rst) begin
      sinkWrEna <= 1'b0;
      sinkData  <= '0;
    end else begin
      sinkWrEna <= strb.outCap;
      if (strb.outCap) sinkData <= coreOutData;
    end
  end

  assert_hold_data_R4: assert property (@(posedge clk) disable iff (rst)
    (!strb.pad && !strb.pop) |=> $stable(coreData));
  assert_sink_write_R8: assert property (@(posedge clk) disable iff (rst)
    strb.outCap |=> sinkWrEna);
endmodule

// File: rtl/lsb_top.sv
module lsb_top
  import lsb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srcDav,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcEna,
  output logic              coreValid,
  input  logic              coreReady,
  output logic [DATA_W-1:0] coreData,
  output logic              coreSop,
  output logic              coreEop,
  input  logic              flushIn,
  input  logic              coreOutValid,
  input  logic [DATA_W-1:0] coreOutData,
  output logic              coreOutReady,
  input  logic              sinkRoom,
  output logic              sinkWrEna,
  output logic [DATA_W-1:0] sinkData
);
  bufStrobe_t strb;

  lsb_ctrl #(.FRAME_LEN(FRAME_LEN)) uCtrl (
    .clk(clk), .rst(rst), .srcDav(srcDav), .srcEna(srcEna),
    .coreReady(coreReady), .coreValid(coreValid), .coreSop(coreSop),
    .coreEop(coreEop), .flushIn(flushIn), .coreOutValid(coreOutValid),
    .sinkRoom(sinkRoom), .coreOutReady(coreOutReady), .strb(strb)
  );

  lsb_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .srcData(srcData),
    .coreData(coreData), .coreOutData(coreOutData),
    .sinkWrEna(sinkWrEna), .sinkData(sinkData)
  );
endmodule

// File: tb/sim_lsb_top.sv
`timescale 1ns/1ps
module sim_lsb_top;
  localparam int DW = 16;
  localparam int FL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic srcDav = 1'b0, coreReady = 1'b0, flushIn = 1'b0;
  logic coreOutValid = 1'b0, sinkRoom = 1'b0;
  logic [DW-1:0] srcData = '0, coreOutData = '0;
  logic srcEna, coreValid, coreSop, coreEop, coreOutReady, sinkWrEna;
  logic [DW-1:0] coreData, sinkData;

  always #2.5 clk = ~clk;

  lsb_top #(.DATA_W(DW), .FRAME_LEN(FL)) u0 (
    .clk(clk), .rst(rst), .srcDav(srcDav), .srcData(srcData), .srcEna(srcEna),
    .coreValid(coreValid), .coreReady(coreReady), .coreData(coreData),
    .coreSop(coreSop), .coreEop(coreEop), .flushIn(flushIn),
    .coreOutValid(coreOutValid), .coreOutData(coreOutData),
    .coreOutReady(coreOutReady), .sinkRoom(sinkRoom),
    .sinkWrEna(sinkWrEna), .sinkData(sinkData)
  );

  // {davMask, readyMask, frames}
  localparam logic [23:0] VEC [0:4] = '{
    {8'hFF, 8'hFF, 8'd3}, {8'hB7, 8'hFF, 8'd2}, {8'hFF, 8'h5A, 8'd3},
    {8'h6D, 8'hC3, 8'd4}, {8'hFF, 8'h0F, 8'd2}
  };

  int errs = 0, checks = 0;
  int nextVal, expVal, accCnt, reqCnt;
  bit pend, outPend, expectPad, prevStall, done = 0;
  logic [DW-1:0] outPendData, prevData;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearModel();
    nextVal = 0; expVal = 0; accCnt = 0; reqCnt = 0;
    pend = 0; outPend = 0; expectPad = 0; prevStall = 0;
  endtask

  task automatic doReset(input bit withChecks);
    @(negedge clk);
    rst = 1; srcDav = 1; coreReady = 0; flushIn = 0; coreOutValid = 0; sinkRoom = 1;
    #1;
    if (withChecks) check(srcEna == 1'b0, "R1 srcEna in reset", int'(srcEna), 0);
    repeat (2) @(negedge clk);
    #1;
    if (withChecks) begin
      check(coreValid == 1'b0, "R1 coreValid in reset", int'(coreValid), 0);
      check(sinkWrEna == 1'b0, "R1 sinkWrEna in reset", int'(sinkWrEna), 0);
      check(srcEna == 1'b0, "R1 srcEna held in reset", int'(srcEna), 0);
    end
    @(negedge clk);
    rst = 0; srcDav = 0;
    #1;
    if (withChecks) check(coreValid == 1'b0, "R1 coreValid after release", int'(coreValid), 0);
    clearModel();
  endtask

  task automatic cycle(input bit dav, input bit rdy, input bit flush,
                       input bit ov, input logic [DW-1:0] od, input bit room);
    @(negedge clk);
    srcDav = dav; coreReady = rdy; flushIn = flush;
    coreOutValid = ov; coreOutData = od; sinkRoom = room;
    if (pend) begin srcData = DW'(nextVal); nextVal++; end
    else srcData = DW'($urandom);
    #1;
    // output side, R8
    check(coreOutReady == room, "R8 ready follows room", int'(coreOutReady), int'(room));
    if (outPend)
      check(sinkWrEna && sinkData == outPendData, "R8 sink write",
            int'(sinkData), int'(outPendData));
    else
      check(!sinkWrEna, "R8 no sink write", int'(sinkWrEna), 0);
    outPend = ov && room; outPendData = od;
    // zero-latency hold, R4
    if (prevStall)
      check(coreValid && coreData == prevData, "R4 hold under backpressure",
            int'(coreData), int'(prevData));
    prevStall = coreValid && !rdy && !expectPad;
    prevData = coreData;
    // core side transfer, R3/R6/R7
    if (coreValid && rdy) begin
      if (expectPad)
        check(coreData == '0, "R7 padding data", int'(coreData), 0);
      else
        check(coreData == DW'(expVal), "R3 sample order", int'(coreData), expVal);
      check(coreSop == ((accCnt % FL) == 0), "R6 sop", int'(coreSop), int'((accCnt % FL) == 0));
      check(coreEop == ((accCnt % FL) == FL - 1), "R6 eop", int'(coreEop),
            int'((accCnt % FL) == FL - 1));
      if (!expectPad) expVal++;
      accCnt++;
    end
    pend = srcEna && dav;
    if (pend) reqCnt++;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      check(1'b0, "R3 watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    clearModel();
    // R1 reset state
    doReset(1);

    // table of stimulus patterns: R2 R3 R4 R6 R8
    for (int v = 0; v < 5; v++) begin
      logic [7:0] davM, rdyM;
      int target;
      davM = VEC[v][23:16]; rdyM = VEC[v][15:8]; target = int'(VEC[v][7:0]) * FL;
      doReset(0);
      for (int c = 0; c < 2000; c++) begin
        cycle(davM[c % 8] && (reqCnt < target), rdyM[(c * 3) % 8], 1'b0,
              davM[(c + 3) % 8], DW'(c * 7 + v), rdyM[(c + 5) % 8]);
        if (accCnt == target) break;
      end
      check(accCnt == target, "R3 beats per run", accCnt, target);
      for (int c = 0; c < 5; c++) cycle(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b1);
      check(accCnt == target, "R3 no duplicate beats", accCnt, target);
      check(reqCnt == target, "R2 requests match beats", reqCnt, target);
    end

    // R2: data wiggle with dav low yields nothing
    doReset(0);
    for (int c = 0; c < 10; c++) cycle(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    check(accCnt == 0 && !coreValid, "R2 no beat without request", accCnt, 0);

    // R9: stall from empty, exactly two requests
    doReset(0);
    for (int c = 0; c < 10; c++) cycle(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    check(reqCnt == 2, "R9 requests during stall", reqCnt, 2);
    check(!srcEna, "R9 enable low when full", int'(srcEna), 0);
    check(coreValid && coreData == '0, "R4 first beat held", int'(coreData), 0);
    for (int c = 0; c < 6; c++) cycle(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    check(accCnt == 2, "R9 both buffered beats delivered", accCnt, 2);

    // R5: full throughput
    doReset(0);
    for (int c = 0; c < 20; c++) cycle(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    check(accCnt == 18, "R5 beats in 20 cycles", accCnt, 18);

    // R7: flush padding after source idle
    doReset(0);
    expectPad = 1;
    for (int c = 0; c < FL + 2; c++) cycle(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    check(accCnt == FL + 2, "R7 padding beats", accCnt, FL + 2);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    check(!coreValid, "R7 valid drops after flush", int'(coreValid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule